// File: doc/BRIEF.md
# Two-Level Armed Address Watchpoint

This block watches a stream of bus transactions, each an address with a valid strobe. It compares every valid address against a programmed value under a programmed bit mask. When a compare succeeds while the monitor is armed, the monitor records a trigger. It raises a one-cycle hit pulse and, if software has allowed it, a one-cycle pulse on an external trigger pin meant for a logic analyzer. The monitor then stays in its triggered state until software clears it or turns it off.

Two arming modes are available. In immediate mode the monitor is armed as soon as it is enabled, so the first matching transaction triggers it. In two-level mode the monitor first waits for a pulse on a separate arming-event input. Matching transactions before that pulse are ignored. Software programs the compare value, the mask and a small control word through a single register write port. It can read the monitor's progress from a two-bit state output.

Top module: `wpt_watchpoint`

## Requirements
- R1: A transaction matches only when `bus_valid` is 1 and `bus_addr` equals the compare register on every bit where the mask register holds 1. Mask bits at 0 are don't-care. After reset the compare register is 0 and the mask is all ones.
- R2: After reset `mon_state` is 0 (off), and `mon_hit` and `mon_trig` are 0.
- R3: The register port selects the control word with `cfg_sel`=0. Its bit 0 is enable, bit 1 is two-level mode and bit 2 is trigger-pin enable. `cfg_sel`=1 writes the compare value and `cfg_sel`=2 writes the mask. A written value takes effect one cycle after the write. In the cycle after that, an enabled monitor leaves state 0 for state 1 (waiting for arm event) in two-level mode, or for state 2 (armed) in immediate mode.
- R4: In state 2, a matching transaction moves the monitor to state 3 (triggered) on the next clock edge. `mon_hit` is then 1 for exactly that one cycle.
- R5: In state 1, matching transactions have no effect. A pulse on `arm_evt` moves the monitor to state 2 on the next edge. After that, the first match triggers it.
- R6: If `arm_evt` and a match fall in the same cycle while in state 1, the monitor moves to state 2 only, with no hit in that cycle.
- R7: `mon_trig` pulses in the same cycle as `mon_hit` when the trigger-pin enable bit was 1 during the matching cycle. Otherwise it stays 0.
- R8: State 3 holds, and further matches produce no hit, until a clear or a disable.
- R9: A write with `cfg_sel`=3 and data bit 0 set is a clear. In any enabled state it restarts the monitor on the next edge, to state 1 in two-level mode or state 2 in immediate mode. A clear takes priority over a match in the same cycle.
- R10: When the enable bit is 0, the monitor is in state 0 on the next edge, with `mon_hit` and `mon_trig` at 0.
- R11: `arm_evt` has no effect in states 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 compare, 2 mask, 3 clear |
| cfg_wdata | input | ADDR_W | Register write data |
| bus_valid | input | 1 | Transaction valid |
| bus_addr | input | ADDR_W | Transaction address |
| arm_evt | input | 1 | Arming-event pulse for two-level mode |
| mon_hit | output | 1 | One-cycle pulse on trigger |
| mon_trig | output | 1 | One-cycle external trigger pulse when allowed |
| mon_state | output | 2 | 0 off, 1 waiting for arm, 2 armed, 3 triggered |

## Verification
Two pairs of events can fall in the same cycle. One is an arming event with a matching address while the monitor waits. The other is a clear write with a matching address while it is armed or triggered. Directed steps drive each pair together on purpose. They expect the state to advance to armed, or to restart, with no hit pulse in either case. The random phase draws arming pulses, clears and near-miss addresses independently, so these pairs recur many times. A bench model that steps the state with arm-before-match and clear-before-match ordering judges every cycle.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_ARM  = 2'd1,
        ST_ARMED     = 2'd2,
        ST_TRIGGERED = 2'd3
    } mon_state_e;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_CTL   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CMP   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MASK  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CLEAR = 2'd3;

    localparam int CTL_W = 3;

    typedef struct packed {
        logic trig_en;    // bit 2
        logic two_level;  // bit 1
        logic enable;     // bit 0
    } ctl_t;

endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output ctl_t              ctl_o,
    output logic [ADDR_W-1:0] cmp_o,
    output logic [ADDR_W-1:0] mask_o,
    output logic              clr_o
);

    typedef struct packed {
        ctl_t              ctl;
        logic [ADDR_W-1:0] cmp;
        logic [ADDR_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            unique case (cfg_sel)
                SEL_CTL:  cfg_d.ctl  = ctl_t'(cfg_wdata[CTL_W-1:0]);
                SEL_CMP:  cfg_d.cmp  = cfg_wdata;
                SEL_MASK: cfg_d.mask = cfg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ctl  <= '0;
            cfg_q.cmp  <= '0;
            cfg_q.mask <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctl_o  = cfg_q.ctl;
    assign cmp_o  = cfg_q.cmp;
    assign mask_o = cfg_q.mask;
    assign clr_o  = cfg_wr && (cfg_sel == SEL_CLEAR) && cfg_wdata[0];

    // R3: a control write is visible on the next cycle
    a_r3_ctl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_CTL) |=> (ctl_o == ctl_t'($past(cfg_wdata[CTL_W-1:0]))));

    // R3: other selects leave the control word alone
    a_r3_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_sel == SEL_CTL) |=> $stable(ctl_o));

endmodule

// File: rtl/wpt_addr_match.sv
module wpt_addr_match #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] cmp,
    input  logic [ADDR_W-1:0] mask,
    output logic              match_o
);

    logic [ADDR_W-1:0] bit_miss;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_miss[i] = mask[i] & (bus_addr[i] ^ cmp[i]);
    end

    assign match_o = bus_valid && (bit_miss == '0);

    // R1: no match without a valid transaction
    a_r1_valid_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !match_o);

    // R1: a fully masked-off compare matches any valid transaction
    a_r1_mask_zero_any: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && mask == '0) |-> match_o);

endmodule

// File: rtl/wpt_trig_fsm.sv
module wpt_trig_fsm
    import wpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       two_level,
    input  logic       trig_en,
    input  logic       clr,
    input  logic       arm_evt,
    input  logic       match,
    output mon_state_e state_o,
    output logic       hit_o,
    output logic       trig_o
);

    typedef struct packed {
        mon_state_e st;
        logic       hit;
        logic       trig;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    mon_state_e start_st;

    assign start_st = two_level ? ST_WAIT_ARM : ST_ARMED;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.hit  = 1'b0;
        fsm_d.trig = 1'b0;
        if (!en) begin
            fsm_d.st = ST_IDLE;
        end else if (fsm_q.st == ST_IDLE || clr) begin
            fsm_d.st = start_st;
        end else begin
            unique case (fsm_q.st)
                ST_WAIT_ARM: begin
                    if (arm_evt) fsm_d.st = ST_ARMED;
                end
                ST_ARMED: begin
                    if (match) begin
                        fsm_d.st   = ST_TRIGGERED;
                        fsm_d.hit  = 1'b1;
                        fsm_d.trig = trig_en;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st   <= ST_IDLE;
            fsm_q.hit  <= 1'b0;
            fsm_q.trig <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;
    assign hit_o   = fsm_q.hit;
    assign trig_o  = fsm_q.trig;

    a_r10_off_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_o == ST_IDLE && !hit_o && !trig_o));

    a_r4_hit_from_armed_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(state_o) == ST_ARMED && $past(match) && state_o == ST_TRIGGERED));

    a_r4_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);

    a_r7_trig_gated: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (hit_o && $past(trig_en)));

    a_r6_no_hit_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_WAIT_ARM) |=> !hit_o);

    a_r5_arm_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && state_o == ST_WAIT_ARM && arm_evt) |=> (state_o == ST_ARMED));

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && state_o == ST_WAIT_ARM && !arm_evt) |=> (state_o == ST_WAIT_ARM));

    a_r8_triggered_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && state_o == ST_TRIGGERED) |=> (state_o == ST_TRIGGERED && !hit_o));

    a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr && state_o != ST_IDLE) |=>
            (!hit_o && state_o == ($past(two_level) ? ST_WAIT_ARM : ST_ARMED)));

    a_r11_armed_ignores_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && state_o == ST_ARMED && !match) |=> (state_o == ST_ARMED));

endmodule

// File: rtl/wpt_watchpoint.sv
module wpt_watchpoint
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              arm_evt,
    output logic              mon_hit,
    output logic              mon_trig,
    output logic [1:0]        mon_state
);

    ctl_t              ctl;
    logic [ADDR_W-1:0] cmp;
    logic [ADDR_W-1:0] mask;
    logic              clr;
    logic              match;
    mon_state_e        st;

    wpt_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ctl_o     (ctl),
        .cmp_o     (cmp),
        .mask_o    (mask),
        .clr_o     (clr)
    );

    wpt_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .cmp       (cmp),
        .mask      (mask),
        .match_o   (match)
    );

    wpt_trig_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl.enable),
        .two_level (ctl.two_level),
        .trig_en   (ctl.trig_en),
        .clr       (clr),
        .arm_evt   (arm_evt),
        .match     (match),
        .state_o   (st),
        .hit_o     (mon_hit),
        .trig_o    (mon_trig)
    );

    assign mon_state = st;

    // R7: the external pin never pulses without a hit
    a_r7_trig_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mon_trig |-> mon_hit);

endmodule

// File: tb/wpt_watchpoint_tb.sv
module wpt_watchpoint_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          arm_evt = 1'b0;
    logic          mon_hit;
    logic          mon_trig;
    logic [1:0]    mon_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    int            m_st = 0;
    bit            m_hit = 0, m_trig = 0;
    bit            m_en = 0, m_two = 0, m_ten = 0;
    logic [AW-1:0] m_cmp = '0;
    logic [AW-1:0] m_mask = '1;

    always #4 clk = ~clk;

    wpt_watchpoint #(.ADDR_W(AW)) dut_i (
        .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata,
        .bus_valid, .bus_addr, .arm_evt,
        .mon_hit, .mon_trig, .mon_state
    );

    function automatic bit f_match(bit v, logic [AW-1:0] a, logic [AW-1:0] c, logic [AW-1:0] m);
        return v && (((a ^ c) & m) == '0);
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(bit wr, logic [1:0] sel, logic [AW-1:0] d,
                              bit v, logic [AW-1:0] a, bit arm);
        bit mt, clr;
        int start;
        mt    = f_match(v, a, m_cmp, m_mask);
        clr   = wr && sel == 2'd3 && d[0];
        start = m_two ? 1 : 2;
        m_hit = 0;
        m_trig = 0;
        if (!m_en) m_st = 0;
        else if (m_st == 0 || clr) m_st = start;
        else if (m_st == 1) begin
            if (arm) m_st = 2;
        end else if (m_st == 2) begin
            if (mt) begin
                m_st = 3; m_hit = 1; m_trig = m_ten;
            end
        end
        if (wr) begin
            case (sel)
                2'd0: begin m_en = d[0]; m_two = d[1]; m_ten = d[2]; end
                2'd1: m_cmp = d;
                2'd2: m_mask = d;
                default: ;
            endcase
        end
    endtask

    // apply one cycle of stimulus at a falling edge, return at the next falling edge
    task automatic cyc(bit wr, logic [1:0] sel, logic [AW-1:0] d,
                       bit v, logic [AW-1:0] a, bit arm);
        cfg_wr = wr; cfg_sel = sel; cfg_wdata = d;
        bus_valid = v; bus_addr = a; arm_evt = arm;
        model_step(wr, sel, d, v, a, arm);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_c();
        cyc(0, 2'd0, '0, 0, '0, 0);
    endtask

    task automatic expect_out(string req, int st, bit h, bit t);
        chk({req, " state"}, AW'(mon_state), AW'(st));
        chk({req, " hit"}, AW'(mon_hit), AW'(h));
        chk({req, " trig"}, AW'(mon_trig), AW'(t));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7001));
        repeat (3) @(negedge clk);
        // R2: reset state
        expect_out("R2", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R2", 0, 0, 0);

        // program compare and mask, then enable immediate with trigger pin
        cyc(1, 2'd1, 32'h1000_0040, 0, '0, 0);
        cyc(1, 2'd2, 32'hFFFF_FFF0, 0, '0, 0);
        cyc(1, 2'd0, 32'h5, 0, '0, 0);
        chk("R3 still off", AW'(mon_state), 0);
        idle_c();
        chk("R3 immediate start", AW'(mon_state), 2);

        // R1: miss on unmasked bit, and no match without valid
        cyc(0, 2'd0, '0, 1, 32'h1000_0050, 0);
        expect_out("R1 miss", 2, 0, 0);
        cyc(0, 2'd0, '0, 0, 32'h1000_0044, 0);
        expect_out("R1 not valid", 2, 0, 0);
        // R4 and R7: hit with trigger pin
        cyc(0, 2'd0, '0, 1, 32'h1000_004C, 0);
        expect_out("R4 R7 hit", 3, 1, 1);
        idle_c();
        expect_out("R4 pulse ends", 3, 0, 0);
        // R8: stays triggered
        cyc(0, 2'd0, '0, 1, 32'h1000_0040, 0);
        expect_out("R8 hold", 3, 0, 0);
        // R11: arm event in triggered state ignored
        cyc(0, 2'd0, '0, 0, '0, 1);
        expect_out("R11 triggered", 3, 0, 0);
        // R9: clear
        cyc(1, 2'd3, 32'h1, 0, '0, 0);
        expect_out("R9 clear", 2, 0, 0);
        // R7: trigger pin off
        cyc(1, 2'd0, 32'h1, 0, '0, 0);
        cyc(0, 2'd0, '0, 1, 32'h1000_0041, 0);
        expect_out("R7 pin off", 3, 1, 0);
        // R9: clear beats a match in the same cycle
        cyc(1, 2'd3, 32'h1, 0, '0, 0);
        cyc(1, 2'd3, 32'h1, 1, 32'h1000_0040, 0);
        expect_out("R9 clear priority", 2, 0, 0);
        // R11: arm in armed state ignored
        cyc(0, 2'd0, '0, 0, '0, 1);
        expect_out("R11 armed", 2, 0, 0);

        // two-level mode
        cyc(1, 2'd0, 32'h7, 0, '0, 0);
        cyc(1, 2'd3, 32'h1, 0, '0, 0);
        expect_out("R9 two-level restart", 1, 0, 0);
        cyc(0, 2'd0, '0, 1, 32'h1000_0040, 0);
        expect_out("R5 match ignored", 1, 0, 0);
        cyc(0, 2'd0, '0, 1, 32'h1000_0040, 1);
        expect_out("R6 arm only", 2, 0, 0);
        cyc(0, 2'd0, '0, 1, 32'h1000_0048, 0);
        expect_out("R5 armed hit", 3, 1, 1);

        // R10: disable
        cyc(1, 2'd0, 32'h0, 0, '0, 0);
        idle_c();
        expect_out("R10 off", 0, 0, 0);
        cyc(0, 2'd0, '0, 1, 32'h1000_0040, 1);
        expect_out("R11 idle", 0, 0, 0);
        // R1: all-zero mask matches any address
        cyc(1, 2'd2, 32'h0, 0, '0, 0);
        cyc(1, 2'd0, 32'h1, 0, '0, 0);
        idle_c();
        cyc(0, 2'd0, '0, 1, 32'hDEAD_BEEF, 0);
        expect_out("R1 mask zero", 3, 1, 0);
        cyc(1, 2'd2, 32'hFFFF_FF00, 0, '0, 0);

        // random phase against bench model
        for (int i = 0; i < 4000; i++) begin
            bit wr, v, arm;
            logic [1:0] sel;
            logic [AW-1:0] d, a;
            wr  = ($urandom_range(0, 99) < 8);
            sel = 2'($urandom_range(0, 3));
            d   = $urandom();
            if (wr && sel == 2'd0) d[0] = ($urandom_range(0, 9) != 0);
            if (wr && sel == 2'd2) d = {$urandom()} | 32'hFFFF_0000;
            v   = ($urandom_range(0, 3) != 0);
            a   = ($urandom_range(0, 1) == 1) ? (m_cmp ^ AW'($urandom_range(0, 3))) : AW'($urandom());
            arm = ($urandom_range(0, 9) == 0);
            cyc(wr, sel, d, v, a, arm);
            chk("R3 R5 R9 random state", AW'(mon_state), AW'(m_st));
            chk("R4 random hit", AW'(mon_hit), AW'(m_hit));
            chk("R7 random trig", AW'(mon_trig), AW'(m_trig));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule